// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Sequencer

This block sits next to a small 8-bit processor core and handles interrupt entry and exit for it. It holds a latch for each of several maskable interrupt sources and one for a non-maskable source. It combines those latches with per-source enables and a global interrupt enable. At each instruction boundary it decides whether to take an interrupt.

When an interrupt is taken, an eight-cycle sequence drives the core's memory port and holds `busy` high so the core stalls its fetch. The sequence first clears the global enable and the selected request latch. It then writes the return address high byte, the return address low byte and the status word onto a stack that grows downward. It then reads a two-byte entry address from a vector table, low byte first. A one-cycle `done` pulse marks the cycle in which `pc_out` holds the entry address. A return pulse runs the reverse sequence, which restores the program counter, the status word and the global enable. Accumulator and general register saving is left to software.

The FSM has 14 states. `ST_IDLE` waits for work. The acceptance path is `ST_ACK` → `ST_PUSH_PCH` → `ST_PUSH_PCL` → `ST_PUSH_PSW` → `ST_VEC_LO` → `ST_VEC_HI` → `ST_VEC_CAP` → `ST_LOAD` → `ST_IDLE`. The return path is `ST_POP_PSW` → `ST_POP_PCL` → `ST_POP_PCH` → `ST_POP_CAP` → `ST_RET_DONE` → `ST_IDLE`. `ST_IDLE` goes to `ST_POP_PSW` on `reti`. Otherwise it goes to `ST_ACK` on `instr_done` when an eligible request exists.

Top module: `irq_accept_seq`

## Requirements
- R1: Each request latch is set by a one-cycle high on its request input and stays set until one of three things clears it: reset, a high on its `req_clr` bit, or acceptance of that source. It becomes visible on `irq_pending` / `nmi_pending` the cycle after the request. When a set and a clear hit the same latch in the same cycle, the set wins.
- R2: Acceptance starts only when `instr_done` is high in the idle state and an eligible request is latched. `busy` is then high for exactly 8 cycles, and `done` is high only in the 8th.
- R3: Acceptance clears `iflag` (the global enable) by the second cycle of the sequence. No maskable request is accepted while `iflag` is 0, whatever its index.
- R4: The non-maskable request is accepted whatever the value of `iflag`. Once it is accepted, no request of any kind (including a new non-maskable one) is accepted until a return sequence completes.
- R5: The latch of the accepted source is cleared by the end of the sequence, unless that source requests again in the first sequence cycle.
- R6: In sequence cycles 2, 3 and 4 the block writes three bytes: PC[15:8] at the stack pointer value SP, PC[7:0] at SP-1, and the status word at SP-2. `sp_out` decreases by one after each write. Bit 2 of the stored status word holds the value `iflag` had when the sequence started. Reads and writes never occur in the same cycle.
- R7: In cycles 5 and 6 the block reads the vector low byte at address V and the high byte at V+1. V is `VEC_BASE + 2*i` (FFE0h + 2i by default) for maskable source i, and `NMI_VEC` (FFFEh) for the non-maskable one. In cycle 8 `pc_out` = {high, low}. For example, source 3 reads FFE6h/FFE7h, and bytes 12h and E3h give E312h.
- R8: The non-maskable request beats all others. Among the maskable requests that are pending, enabled and allowed by `iflag`, the lowest index is taken.
- R9: A pending source whose `irq_en` bit is 0 is not accepted and stays pending.
- R10: A `reti` pulse in idle runs a 5-cycle busy sequence. In cycles 1 to 3 it reads SP+1 (status word), SP+2 (PC low byte) and SP+3 (PC high byte), which raises `sp_out` by 3. In cycle 5 `done` is high with the restored `pc_out` and `psw_out`. Afterwards `iflag` equals bit 2 of the restored status word and the non-maskable block is lifted. `sp_out` does not change while idle.
- R11: `ei` sets `iflag` and `di` clears it. `di` wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Maskable request strobes |
| irq_en | input | NSRC | Per-source enables |
| req_clr | input | NSRC | Software clear of request latches |
| nmi_req | input | 1 | Non-maskable request strobe |
| ei | input | 1 | Set global enable |
| di | input | 1 | Clear global enable |
| instr_done | input | 1 | Current instruction completes this cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | AW | Return address from the core |
| psw_in | input | DW | Status word from the core |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_re` |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| busy | output | 1 | Sequence running, core stalls fetch |
| done | output | 1 | `pc_out` is valid this cycle |
| pc_out | output | AW | New program counter |
| psw_out | output | DW | Last restored status word |
| sp_out | output | AW | Stack pointer |
| iflag | output | 1 | Global interrupt enable |
| irq_pending | output | NSRC | Maskable request latches |
| nmi_pending | output | 1 | Non-maskable request latch |

## Verification
Two things can fall in the same cycle: the acceptance clear of a request latch in `ST_ACK`, and a fresh request from the same source. The bench provokes this by pulsing the accepted source's request input in the first busy cycle. It passes if that source is still shown pending after `done`, while the stack and vector traffic stay exactly as for a normal entry. A second overlap is `ei` and `di` in one cycle, which the bench judges by the resulting `iflag`.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_PSW,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_VEC_CAP,
        ST_LOAD,
        ST_POP_PSW,
        ST_POP_PCL,
        ST_POP_PCH,
        ST_POP_CAP,
        ST_RET_DONE
    } seq_state_t;
endpackage

// File: rtl/irq_req_bank.sv
`timescale 1ns/1ps
module irq_req_bank #(
    parameter int NSRC = 4,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_set,
    input  logic [NSRC-1:0] sw_clr,
    input  logic [NSRC-1:0] en,
    input  logic            acc_clr,
    input  logic [IDXW-1:0] acc_idx,
    input  logic            nmi_set,
    input  logic            nmi_acc_clr,
    output logic [NSRC-1:0] pend,
    output logic            nmi_pend,
    output logic            any_ready,
    output logic [IDXW-1:0] pick_idx
);
    logic [NSRC-1:0] ready;

    // one latch per source; a new request beats any clear
    for (genvar g = 0; g < NSRC; g++) begin : g_latch
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (req_set[g])
                pend[g] <= 1'b1;
            else if (sw_clr[g] || (acc_clr && acc_idx == IDXW'(g)))
                pend[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_pend <= 1'b0;
        else if (nmi_set)
            nmi_pend <= 1'b1;
        else if (nmi_acc_clr)
            nmi_pend <= 1'b0;
    end

    assign ready     = pend & en;
    assign any_ready = |ready;

    // lowest index wins
    always_comb begin
        pick_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (ready[i])
                pick_idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/irq_stack_ptr.sv
`timescale 1ns/1ps
module irq_stack_ptr #(
    parameter int          AW      = 16,
    parameter logic [AW-1:0] SP_INIT = 16'h00FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec,
    input  logic          inc,
    output logic [AW-1:0] sp
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= SP_INIT;
        else if (dec)
            sp <= sp - AW'(1);
        else if (inc)
            sp <= sp + AW'(1);
    end
endmodule

// File: rtl/irq_accept_seq.sv
`timescale 1ns/1ps
module irq_accept_seq
    import irq_seq_pkg::*;
#(
    parameter int            NSRC     = 4,
    parameter int            DW       = 8,
    parameter int            AW       = 2 * DW,
    parameter logic [AW-1:0] SP_INIT  = 16'h00FF,
    parameter logic [AW-1:0] VEC_BASE = 16'hFFE0,
    parameter logic [AW-1:0] NMI_VEC  = 16'hFFFE,
    parameter int            IBIT     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] req_clr,
    input  logic            nmi_req,
    input  logic            ei,
    input  logic            di,
    input  logic            instr_done,
    input  logic            reti,
    input  logic [AW-1:0]   pc_in,
    input  logic [DW-1:0]   psw_in,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_we,
    output logic            mem_re,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            busy,
    output logic            done,
    output logic [AW-1:0]   pc_out,
    output logic [DW-1:0]   psw_out,
    output logic [AW-1:0]   sp_out,
    output logic            iflag,
    output logic [NSRC-1:0] irq_pending,
    output logic            nmi_pending
);
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

    seq_state_t      state, state_nx;
    logic [IDXW-1:0] sel_idx, pick_idx;
    logic            sel_nmi, nmi_blk, iflag_r, any_ready;
    logic [AW-1:0]   pc_sv, vec_addr;
    logic [DW-1:0]   psw_sv, psw_save_c, psw_rd, byte_lo, byte_hi;
    logic            go_nmi, go_mask, start_acc;
    logic            sp_dec, sp_inc;

    irq_req_bank #(.NSRC(NSRC), .IDXW(IDXW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_set    (irq_req),
        .sw_clr     (req_clr),
        .en         (irq_en),
        .acc_clr    (state == ST_ACK && !sel_nmi),
        .acc_idx    (sel_idx),
        .nmi_set    (nmi_req),
        .nmi_acc_clr(state == ST_ACK && sel_nmi),
        .pend       (irq_pending),
        .nmi_pend   (nmi_pending),
        .any_ready  (any_ready),
        .pick_idx   (pick_idx)
    );

    irq_stack_ptr #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
        .clk  (clk),
        .rst_n(rst_n),
        .dec  (sp_dec),
        .inc  (sp_inc),
        .sp   (sp_out)
    );

    assign go_nmi    = nmi_pending && !nmi_blk;
    assign go_mask   = !nmi_blk && iflag_r && any_ready;
    assign start_acc = instr_done && (go_nmi || go_mask);
    assign vec_addr  = sel_nmi ? NMI_VEC : VEC_BASE + AW'({sel_idx, 1'b0});

    always_comb begin
        psw_save_c       = psw_in;
        psw_save_c[IBIT] = iflag_r;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (reti)
                    state_nx = ST_POP_PSW;
                else if (start_acc)
                    state_nx = ST_ACK;
            end
            ST_ACK:      state_nx = ST_PUSH_PCH;
            ST_PUSH_PCH: state_nx = ST_PUSH_PCL;
            ST_PUSH_PCL: state_nx = ST_PUSH_PSW;
            ST_PUSH_PSW: state_nx = ST_VEC_LO;
            ST_VEC_LO:   state_nx = ST_VEC_HI;
            ST_VEC_HI:   state_nx = ST_VEC_CAP;
            ST_VEC_CAP:  state_nx = ST_LOAD;
            ST_LOAD:     state_nx = ST_IDLE;
            ST_POP_PSW:  state_nx = ST_POP_PCL;
            ST_POP_PCL:  state_nx = ST_POP_PCH;
            ST_POP_PCH:  state_nx = ST_POP_CAP;
            ST_POP_CAP:  state_nx = ST_RET_DONE;
            ST_RET_DONE: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
            sel_nmi <= 1'b0;
            nmi_blk <= 1'b0;
            iflag_r <= 1'b0;
            pc_sv   <= '0;
            psw_sv  <= '0;
            psw_rd  <= '0;
            byte_lo <= '0;
            byte_hi <= '0;
        end else begin
            if (state == ST_IDLE && !reti && start_acc) begin
                sel_idx <= pick_idx;
                sel_nmi <= go_nmi;
                pc_sv   <= pc_in;
                psw_sv  <= psw_save_c;
            end
            if (state == ST_ACK)
                iflag_r <= 1'b0;
            else if (state == ST_RET_DONE)
                iflag_r <= psw_rd[IBIT];
            else if (di)
                iflag_r <= 1'b0;
            else if (ei)
                iflag_r <= 1'b1;
            if (state == ST_ACK && sel_nmi)
                nmi_blk <= 1'b1;
            else if (state == ST_RET_DONE)
                nmi_blk <= 1'b0;
            if (state == ST_VEC_HI || state == ST_POP_PCH)
                byte_lo <= mem_rdata;
            if (state == ST_VEC_CAP || state == ST_POP_CAP)
                byte_hi <= mem_rdata;
            if (state == ST_POP_PCL)
                psw_rd <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp_out;
        mem_wdata = '0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        unique case (state)
            ST_PUSH_PCH: begin
                mem_we = 1'b1; mem_wdata = pc_sv[AW-1:DW]; sp_dec = 1'b1;
            end
            ST_PUSH_PCL: begin
                mem_we = 1'b1; mem_wdata = pc_sv[DW-1:0]; sp_dec = 1'b1;
            end
            ST_PUSH_PSW: begin
                mem_we = 1'b1; mem_wdata = psw_sv; sp_dec = 1'b1;
            end
            ST_VEC_LO: begin
                mem_re = 1'b1; mem_addr = vec_addr;
            end
            ST_VEC_HI: begin
                mem_re = 1'b1; mem_addr = vec_addr + AW'(1);
            end
            ST_POP_PSW, ST_POP_PCL, ST_POP_PCH: begin
                mem_re = 1'b1; mem_addr = sp_out + AW'(1); sp_inc = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_LOAD) || (state == ST_RET_DONE);
    assign pc_out  = {byte_hi, byte_lo};
    assign psw_out = psw_rd;
    assign iflag   = iflag_r;
endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk #(
    parameter int NSRC = 4,
    parameter int AW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            mem_we,
    input logic            mem_re,
    input logic [AW-1:0]   mem_addr,
    input logic [AW-1:0]   sp_out,
    input logic            iflag,
    input logic [NSRC-1:0] irq_pending,
    input logic [NSRC-1:0] req_clr
);
    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_iflag_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !iflag);
    assert_bus_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    assert_push_at_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp_out));
    assert_push_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out == $past(sp_out) - AW'(1)));
    assert_sp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(sp_out));
    assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_clr == '0) |=>
            ((irq_pending & $past(irq_pending)) == $past(irq_pending)));
endmodule

bind irq_accept_seq irq_accept_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .sp_out     (sp_out),
    .iflag      (iflag),
    .irq_pending(irq_pending),
    .req_clr    (req_clr)
);

// File: tb/tb_irq_accept_seq.sv
`timescale 1ns/1ps
module tb_irq_accept_seq;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0, irq_en = '0, req_clr = '0;
    logic nmi_req = 0, ei = 0, di = 0, instr_done = 0, reti = 0;
    logic [15:0] pc_in = '0;
    logic [7:0]  psw_in = '0, mem_rdata = '0;
    logic mem_we, mem_re, busy, done, iflag, nmi_pending;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, psw_out;
    logic [NS-1:0] irq_pending;

    int nchk = 0, nfail = 0;
    logic [NS-1:0] pend_m = '0, en_m = '0;
    logic nmi_m = 0, iflag_m = 0, blk_m = 0;
    logic [15:0] sp_m = 16'h00FF;
    logic [15:0] spc [0:7];
    logic [7:0]  sps [0:7];
    int depth = 0;
    logic [7:0] stk [0:255];

    always #2.5 clk = ~clk;

    irq_accept_seq dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .req_clr(req_clr), .nmi_req(nmi_req), .ei(ei), .di(di),
        .instr_done(instr_done), .reti(reti), .pc_in(pc_in), .psw_in(psw_in),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .pc_out(pc_out), .psw_out(psw_out), .sp_out(sp_out), .iflag(iflag),
        .irq_pending(irq_pending), .nmi_pending(nmi_pending)
    );

    function automatic logic [7:0] vb(input logic [15:0] a);
        if (a == 16'hFFE6) return 8'h12;
        if (a == 16'hFFE7) return 8'hE3;
        return a[7:0] ^ 8'h3C;
    endfunction

    // synchronous memory model
    always @(posedge clk) begin
        if (mem_we) stk[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= (mem_addr[15:8] == 8'h00) ? stk[mem_addr[7:0]] : vb(mem_addr);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int pick();
        if (nmi_m && !blk_m) return 100;
        if (!blk_m && iflag_m)
            for (int i = 0; i < NS; i++) if (pend_m[i] && en_m[i]) return i;
        return -1;
    endfunction

    task automatic pulse_req(input logic [NS-1:0] m, input logic n);
        irq_req = m; nmi_req = n;
        @(negedge clk);
        irq_req = '0; nmi_req = 0;
        pend_m |= m; nmi_m |= n;
    endtask

    task automatic sw_clear(input logic [NS-1:0] m);
        req_clr = m;
        @(negedge clk);
        req_clr = '0;
        pend_m &= ~m;
    endtask

    task automatic set_flag(input logic e, input logic d);
        ei = e; di = d;
        @(negedge clk);
        ei = 0; di = 0;
        if (d) iflag_m = 0; else if (e) iflag_m = 1;
    endtask

    task automatic set_en(input logic [NS-1:0] m);
        en_m = m; irq_en = m;
    endtask

    task automatic run_accept(input logic [15:0] pc, input logic [7:0] psw, input logic repulse);
        int s;
        logic [15:0] va;
        logic [7:0] pe;
        logic bok;
        s = pick();
        pc_in = pc; psw_in = psw; instr_done = 1;
        @(negedge clk);
        instr_done = 0;
        if (s < 0) begin
            chk("R3 R4 R9 no acceptance", 32'(busy), 32'd0);
            chk("R1 R9 pending held", 32'({nmi_pending, irq_pending}), 32'({nmi_m, pend_m}));
            return;
        end
        va = (s == 100) ? 16'hFFFE : 16'hFFE0 + 16'(2 * s);
        pe = psw; pe[2] = iflag_m;
        bok = 1;
        for (int k = 1; k <= 8; k++) begin
            if (!busy) bok = 0;
            if (k == 1 && repulse && s != 100) irq_req[s] = 1'b1;
            if (k == 2) irq_req = '0;
            case (k)
                2: chk("R6 push PCH", 32'({mem_we, mem_addr, mem_wdata}), 32'({1'b1, sp_m, pc[15:8]}));
                3: chk("R6 push PCL", 32'({mem_we, mem_addr, mem_wdata}), 32'({1'b1, sp_m - 16'd1, pc[7:0]}));
                4: chk("R6 push PSW", 32'({mem_we, mem_addr, mem_wdata}), 32'({1'b1, sp_m - 16'd2, pe}));
                5: chk("R7 R8 vector low read", 32'({mem_re, mem_addr}), 32'({1'b1, va}));
                6: chk("R7 R8 vector high read", 32'({mem_re, mem_addr}), 32'({1'b1, va + 16'd1}));
                7: chk("R2 no done early", 32'(done), 32'd0);
                8: chk("R2 R7 entry address", 32'({done, pc_out}), 32'({1'b1, vb(va + 16'd1), vb(va)}));
                default: ;
            endcase
            @(negedge clk);
        end
        chk("R2 busy for 8 cycles", 32'(bok), 32'd1);
        chk("R2 busy ends", 32'(busy), 32'd0);
        chk("R6 sp minus 3", 32'(sp_out), 32'(sp_m - 16'd3));
        chk("R3 iflag cleared", 32'(iflag), 32'd0);
        sp_m = sp_m - 16'd3; iflag_m = 0;
        if (s == 100) begin nmi_m = 0; blk_m = 1; end
        else pend_m[s] = repulse;
        chk("R5 accepted request cleared", 32'({nmi_pending, irq_pending}), 32'({nmi_m, pend_m}));
        spc[depth] = pc; sps[depth] = pe; depth++;
    endtask

    task automatic run_reti();
        logic [15:0] pcx;
        logic [7:0] psx;
        logic bok;
        reti = 1;
        @(negedge clk);
        reti = 0;
        depth--;
        pcx = spc[depth]; psx = sps[depth];
        bok = 1;
        for (int k = 1; k <= 5; k++) begin
            if (!busy) bok = 0;
            case (k)
                1: chk("R10 pop PSW read", 32'({mem_re, mem_addr}), 32'({1'b1, sp_m + 16'd1}));
                2: chk("R10 pop PCL read", 32'({mem_re, mem_addr}), 32'({1'b1, sp_m + 16'd2}));
                3: chk("R10 pop PCH read", 32'({mem_re, mem_addr}), 32'({1'b1, sp_m + 16'd3}));
                5: chk("R10 restored pc psw", 32'({done, pc_out, psw_out}), 32'({1'b1, pcx, psx}));
                default: ;
            endcase
            @(negedge clk);
        end
        chk("R10 busy 5 cycles", 32'({bok, busy}), 32'({1'b1, 1'b0}));
        chk("R10 sp plus 3", 32'(sp_out), 32'(sp_m + 16'd3));
        chk("R10 iflag restored", 32'(iflag), 32'(psx[2]));
        sp_m = sp_m + 16'd3; iflag_m = psx[2]; blk_m = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int sd;
        sd = $urandom(32'hC0FFEE);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R1 R6 reset state", 32'({busy, iflag, irq_pending, nmi_pending, mem_we, mem_re}), 32'd0);
        chk("R6 reset sp", 32'(sp_out), 32'h00FF);

        // R3: pending enabled source held off while iflag is 0
        set_en(4'hF);
        pulse_req(4'b0010, 0);
        chk("R1 latch visible", 32'(irq_pending), 32'b0010);
        run_accept(16'h1234, 8'hA5, 0);

        // R11: ei and di together, then ei alone
        set_flag(1, 1);
        chk("R11 di wins", 32'(iflag), 32'd0);
        set_flag(1, 0);
        chk("R11 ei sets", 32'(iflag), 32'd1);

        // R8: sources 1 and 3 pending, lowest index taken first
        pulse_req(4'b1000, 0);
        run_accept(16'h4567, 8'h00, 0);
        run_reti();
        // R7: source 3 vector FFE6h gives E312h
        run_accept(16'h89AB, 8'hFF, 0);
        run_reti();

        // R9: disabled source stays pending; R1: software clear
        set_en(4'b1110);
        pulse_req(4'b0001, 0);
        run_accept(16'h1111, 8'h11, 0);
        sw_clear(4'b0001);
        chk("R1 software clear", 32'(irq_pending), 32'd0);

        // collision: re-request in the cycle the latch is cleared
        set_en(4'hF);
        pulse_req(4'b0100, 0);
        run_accept(16'h2222, 8'h22, 1);
        run_reti();
        sw_clear(4'b0100);

        // R4: NMI with iflag 0, then everything blocked until return
        set_flag(0, 1);
        pulse_req(4'b0000, 1);
        run_accept(16'h3333, 8'h30, 0);
        set_flag(1, 0);
        pulse_req(4'b0001, 1);
        run_accept(16'h3334, 8'h31, 0);
        run_reti();
        run_accept(16'h3335, 8'h32, 0);
        run_reti();
        set_flag(1, 0);
        run_accept(16'h3336, 8'h33, 0);
        // nested entry after software re-enables
        set_flag(1, 0);
        pulse_req(4'b0010, 0);
        run_accept(16'h3337, 8'h34, 0);
        run_reti();
        run_reti();

        // constrained random
        for (int it = 0; it < 60; it++) begin
            set_en(4'($urandom));
            pulse_req(4'($urandom), ($urandom % 8) == 0);
            if (($urandom % 4) == 0) sw_clear(4'($urandom));
            if ($urandom % 3 != 0) set_flag(1, 0); else set_flag(0, 1);
            run_accept(16'($urandom), 8'($urandom), ($urandom % 4) == 0);
            while (depth > 0) run_reti();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule